// File: doc/BRIEF.md
# Per-Region Write Lock Map

This block holds the write-lock state of a serial flash array in one bit per protectable region. Most of the array is protected in whole 64 KB blocks. The lowest and the highest 64 KB block are split into 16 sectors of 4 KB each, and every one of those sectors has its own bit. Commands reach the block already decoded, as a valid strobe with an 8-bit opcode and a 24-bit address. Those commands can lock one region, unlock one region, report the lock state of one region, lock everything or unlock everything.

A second, purely combinational port answers one question: may a program or erase at a given address go ahead? When the lock-map scheme is selected (`wps` = 1), the answer comes from the map. A chip erase is allowed only when every bit is clear. When the scheme is not selected, an externally decoded block-protect flag decides alone. A power-up/reset pulse, or the asynchronous reset, returns every bit to the locked state.

Top module: `lock_map`

## Requirements
- R1: After `rst_n` is asserted, and one cycle after a `por_pulse`, every lock bit is 1. `por_pulse` takes precedence over any command in the same cycle.
- R2: The block index is address bits [16 +: log2(NUM_BLOCKS)]. Address bits above that field are ignored, so addresses alias modulo the array size. Each interior block maps to one bit. In block 0 and in block NUM_BLOCKS-1, address bits [15:12] select one of 16 separate bits.
- R3: With `wps`=1 and `chk_chip`=0, `wr_allow` is 1 when the region holding `chk_addr` is unlocked and 0 when it is locked.
- R4: Opcode 8'h36 sets the bit of the addressed region and opcode 8'h39 clears it. Both take effect on the clock edge that samples `cmd_valid`, and neither touches any other bit.
- R5: Opcode 8'h7E sets every bit and opcode 8'h98 clears every bit, one cycle after the command.
- R6: Opcode 8'h3D raises `rd_valid` for exactly the cycle after the command. `rd_data` then holds the region's lock bit in bit 0 and zeros in bits 7..1. A read changes no lock bit.
- R7: With `wps`=0, `wr_allow` equals the inverse of `bp_protect`, whatever the lock map holds.
- R8: With `wps`=1 and `chk_chip`=1 (chip erase), `wr_allow` is 1 only when no lock bit is set.
- R9: A valid command with any other opcode changes no lock bit and raises no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; locks every region |
| por_pulse | input | 1 | Synchronous power-up/software-reset pulse; locks every region |
| cmd_valid | input | 1 | Decoded command strobe |
| cmd_op | input | 8 | Command opcode |
| cmd_addr | input | 24 | Command address |
| wps | input | 1 | 1 selects lock-map protection, 0 selects the block-protect flag |
| bp_protect | input | 1 | Block-protect decision for `chk_addr`, used when `wps`=0 |
| chk_addr | input | 24 | Address of a pending program or erase |
| chk_chip | input | 1 | 1 means the pending operation is a chip erase |
| wr_allow | output | 1 | Pending program/erase may proceed |
| rd_valid | output | 1 | Lock-read response valid |
| rd_data | output | 8 | Lock-read response byte |

## Verification
The assertions assume that `cmd_valid` carries at most one opcode per cycle. They also assume that `por_pulse` is a synchronous input sampled on the same edge as commands. Nothing is assumed about `chk_addr`, because the allow path is purely combinational. The bench drives every input at the falling edge and holds each command for exactly one rising edge. It samples `wr_allow` one time unit after each change of `chk_addr`. It never issues a second command before the response of a lock read has been observed.

// File: rtl/lock_map_pkg.sv
package lock_map_pkg;
  localparam int unsigned SEC_PER_EDGE = 16;
  localparam logic [7:0] OP_LOCK_ONE   = 8'h36;
  localparam logic [7:0] OP_UNLOCK_ONE = 8'h39;
  localparam logic [7:0] OP_READ_ONE   = 8'h3D;
  localparam logic [7:0] OP_LOCK_ALL   = 8'h7E;
  localparam logic [7:0] OP_UNLOCK_ALL = 8'h98;

  // Flat region numbering: bottom sectors first, then the interior
  // blocks, then the top sectors.
  function automatic int unsigned region_of(input logic [23:0] addr,
                                            input int unsigned nb,
                                            input int unsigned blk_w);
    int unsigned blk;
    int unsigned sec;
    blk = int'(addr[23:16]) & ((1 << blk_w) - 1);
    sec = int'(addr[15:12]);
    if (blk == 0)
      return sec;
    else if (blk == nb - 1)
      return SEC_PER_EDGE + (nb - 2) + sec;
    else
      return SEC_PER_EDGE + blk - 1;
  endfunction
endpackage

// File: rtl/lock_cmd_decode.sv
module lock_cmd_decode (
  input  logic       cmd_valid,
  input  logic [7:0] cmd_op,
  output logic       do_lock,
  output logic       do_unlock,
  output logic       do_read,
  output logic       do_glock,
  output logic       do_gunlock
);
  import lock_map_pkg::*;
  always_comb begin
    do_lock    = cmd_valid && (cmd_op == OP_LOCK_ONE);
    do_unlock  = cmd_valid && (cmd_op == OP_UNLOCK_ONE);
    do_read    = cmd_valid && (cmd_op == OP_READ_ONE);
    do_glock   = cmd_valid && (cmd_op == OP_LOCK_ALL);
    do_gunlock = cmd_valid && (cmd_op == OP_UNLOCK_ALL);
  end
endmodule

// File: rtl/lock_bit_array.sv
module lock_bit_array #(
  parameter int unsigned NREG  = 94,
  parameter int unsigned REG_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_pulse,
  input  logic             do_lock,
  input  logic             do_unlock,
  input  logic             do_glock,
  input  logic             do_gunlock,
  input  logic [REG_W-1:0] sel,
  output logic [NREG-1:0]  lock_vec
);
  for (genvar i = 0; i < NREG; i++) begin : g_bit
    logic bit_q;
    logic hit;
    assign hit = (sel == REG_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  bit_q <= 1'b1;
      else if (por_pulse || do_glock) bit_q <= 1'b1;
      else if (do_gunlock)         bit_q <= 1'b0;
      else if (hit && do_lock)     bit_q <= 1'b1;
      else if (hit && do_unlock)   bit_q <= 1'b0;
    end
    assign lock_vec[i] = bit_q;
  end
endmodule

// File: rtl/lock_allow.sv
module lock_allow #(
  parameter int unsigned NREG  = 94,
  parameter int unsigned REG_W = 7
) (
  input  logic [NREG-1:0]  lock_vec,
  input  logic [REG_W-1:0] chk_sel,
  input  logic [REG_W-1:0] rd_sel,
  input  logic             wps,
  input  logic             bp_protect,
  input  logic             chk_chip,
  output logic             any_locked,
  output logic             all_locked,
  output logic             rd_bit,
  output logic             wr_allow
);
  logic region_locked;
  always_comb begin
    any_locked    = |lock_vec;
    all_locked    = &lock_vec;
    region_locked = lock_vec[chk_sel];
    rd_bit        = lock_vec[rd_sel];
    if (!wps)          wr_allow = !bp_protect;
    else if (chk_chip) wr_allow = !any_locked;
    else               wr_allow = !region_locked;
  end
endmodule

// File: rtl/lock_map.sv
module lock_map #(
  parameter int unsigned NUM_BLOCKS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        por_pulse,
  input  logic        cmd_valid,
  input  logic [7:0]  cmd_op,
  input  logic [23:0] cmd_addr,
  input  logic        wps,
  input  logic        bp_protect,
  input  logic [23:0] chk_addr,
  input  logic        chk_chip,
  output logic        wr_allow,
  output logic        rd_valid,
  output logic [7:0]  rd_data
);
  import lock_map_pkg::*;
  localparam int unsigned BLK_W = $clog2(NUM_BLOCKS);
  localparam int unsigned NREG  = (NUM_BLOCKS - 2) + 2 * SEC_PER_EDGE;
  localparam int unsigned REG_W = $clog2(NREG);

  logic do_lock, do_unlock, do_read, do_glock, do_gunlock;
  logic [REG_W-1:0] cmd_sel, chk_sel;
  logic [NREG-1:0] lock_vec;
  logic any_locked, all_locked, rd_bit;

  assign cmd_sel = REG_W'(region_of(cmd_addr, NUM_BLOCKS, BLK_W));
  assign chk_sel = REG_W'(region_of(chk_addr, NUM_BLOCKS, BLK_W));

  lock_cmd_decode u_dec (
    .cmd_valid (cmd_valid), .cmd_op (cmd_op),
    .do_lock (do_lock), .do_unlock (do_unlock), .do_read (do_read),
    .do_glock (do_glock), .do_gunlock (do_gunlock)
  );

  lock_bit_array #(.NREG(NREG), .REG_W(REG_W)) u_arr (
    .clk (clk), .rst_n (rst_n), .por_pulse (por_pulse),
    .do_lock (do_lock), .do_unlock (do_unlock),
    .do_glock (do_glock), .do_gunlock (do_gunlock),
    .sel (cmd_sel), .lock_vec (lock_vec)
  );

  lock_allow #(.NREG(NREG), .REG_W(REG_W)) u_allow (
    .lock_vec (lock_vec), .chk_sel (chk_sel), .rd_sel (cmd_sel),
    .wps (wps), .bp_protect (bp_protect), .chk_chip (chk_chip),
    .any_locked (any_locked), .all_locked (all_locked),
    .rd_bit (rd_bit), .wr_allow (wr_allow)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
    end else begin
      rd_valid <= do_read;
      if (do_read) rd_data <= {7'b0, rd_bit};
    end
  end
endmodule

// File: rtl/lock_map_chk.sv
module lock_map_chk #(
  parameter int unsigned NREG = 94
) (
  input logic            clk,
  input logic            rst_n,
  input logic            por_pulse,
  input logic            cmd_valid,
  input logic [7:0]      cmd_op,
  input logic            do_lock,
  input logic            do_unlock,
  input logic            do_read,
  input logic            do_glock,
  input logic            do_gunlock,
  input logic [NREG-1:0] lock_vec,
  input logic            any_locked,
  input logic            all_locked,
  input logic            wps,
  input logic            bp_protect,
  input logic            chk_chip,
  input logic            wr_allow,
  input logic            rd_valid,
  input logic [7:0]      rd_data
);
  AST_POR_LOCKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    por_pulse |=> ($countones(lock_vec) == NREG)); // R1
  AST_GLOBAL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    do_glock |=> all_locked); // R5
  AST_GLOBAL_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (do_gunlock && !por_pulse) |=> !any_locked); // R5
  AST_SINGLE_LOCK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (do_lock && !por_pulse) |=> ($countones(lock_vec) <= $past($countones(lock_vec)) + 1)
      && ($countones(lock_vec) >= $past($countones(lock_vec)))); // R4
  AST_SINGLE_UNLOCK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (do_unlock && !por_pulse) |=> ($countones(lock_vec) + 1 >= $past($countones(lock_vec)))
      && ($countones(lock_vec) <= $past($countones(lock_vec)))); // R4
  AST_READ_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    do_read |=> rd_valid); // R6
  AST_READ_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_data[7:1] == 7'd0)); // R6
  AST_READ_KEEPS_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (do_read && !por_pulse) |=> $stable(lock_vec)); // R6
  AST_OTHER_OP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !por_pulse && !do_lock && !do_unlock && !do_glock && !do_gunlock)
      |=> $stable(lock_vec)); // R9
  AST_BP_GOVERNS: assert property (@(posedge clk) disable iff (!rst_n)
    !wps |-> (wr_allow != bp_protect)); // R7
  AST_CHIP_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wps && chk_chip && any_locked) |-> !wr_allow); // R8
endmodule

bind lock_map lock_map_chk #(.NREG(NREG)) u_chk (.*);

// File: tb/lock_map_tb.sv
module lock_map_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic por_pulse = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_op = 8'h00;
  logic [23:0] cmd_addr = 24'h0;
  logic wps = 1'b1;
  logic bp_protect = 1'b0;
  logic [23:0] chk_addr = 24'h0;
  logic chk_chip = 1'b0;
  logic wr_allow, rd_valid;
  logic [7:0] rd_data;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lock_map u_dut (.*);

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic send(input logic [7:0] op, input logic [23:0] addr);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic allow_at(input logic [23:0] addr, input logic chip, input logic exp, input string req);
    chk_addr = addr; chk_chip = chip;
    #1;
    check({7'b0, wr_allow}, {7'b0, exp}, req, $sformatf("allow @%06h chip=%0b", addr, chip));
  endtask

  task automatic t_reset;
    wps = 1'b1;
    allow_at(24'h000000, 1'b0, 1'b0, "R1");
    allow_at(24'h123456, 1'b0, 1'b0, "R1");
    allow_at(24'h3FF000, 1'b0, 1'b0, "R1");
    allow_at(24'h000000, 1'b1, 1'b0, "R1");
    check(rd_valid, 1'b0, "R1", "rd_valid after reset");
  endtask

  task automatic t_interior;
    send(8'h39, 24'h051234);
    allow_at(24'h050000, 1'b0, 1'b1, "R4");
    allow_at(24'h05FFFF, 1'b0, 1'b1, "R2");
    allow_at(24'h060000, 1'b0, 1'b0, "R3");
    allow_at(24'h04FFFF, 1'b0, 1'b0, "R4");
  endtask

  task automatic t_edge_sectors;
    send(8'h39, 24'h003000);
    allow_at(24'h003FFF, 1'b0, 1'b1, "R2");
    allow_at(24'h002FFF, 1'b0, 1'b0, "R2");
    allow_at(24'h004000, 1'b0, 1'b0, "R2");
    send(8'h39, 24'h3FF800);
    allow_at(24'h3FF000, 1'b0, 1'b1, "R2");
    allow_at(24'h3FE000, 1'b0, 1'b0, "R2");
  endtask

  task automatic t_read;
    send(8'h3D, 24'h051000);
    check(rd_valid, 1'b1, "R6", "rd_valid unlocked read");
    check(rd_data, 8'h00, "R6", "rd_data unlocked");
    send(8'h3D, 24'h070000);
    check(rd_valid, 1'b1, "R6", "rd_valid locked read");
    check(rd_data, 8'h01, "R6", "rd_data locked");
    @(negedge clk);
    check(rd_valid, 1'b0, "R6", "rd_valid single cycle");
    allow_at(24'h050000, 1'b0, 1'b1, "R6");
  endtask

  task automatic t_relock;
    send(8'h36, 24'h058000);
    allow_at(24'h050000, 1'b0, 1'b0, "R4");
    allow_at(24'h003000, 1'b0, 1'b1, "R4");
  endtask

  task automatic t_wps_off;
    wps = 1'b0; bp_protect = 1'b0;
    allow_at(24'h100000, 1'b0, 1'b1, "R7");
    bp_protect = 1'b1;
    allow_at(24'h003000, 1'b0, 1'b0, "R7");
    wps = 1'b1; bp_protect = 1'b0;
  endtask

  task automatic t_global;
    send(8'h98, 24'h0);
    allow_at(24'h200000, 1'b0, 1'b1, "R5");
    allow_at(24'h000000, 1'b1, 1'b1, "R8");
    send(8'h36, 24'h00F000);
    allow_at(24'h000000, 1'b1, 1'b0, "R8");
    allow_at(24'h00E000, 1'b0, 1'b1, "R4");
    send(8'h7E, 24'h0);
    allow_at(24'h00E000, 1'b0, 1'b0, "R5");
    allow_at(24'h3FF800, 1'b0, 1'b0, "R5");
  endtask

  task automatic t_ignored;
    send(8'h98, 24'h0);
    send(8'h02, 24'h100000);
    send(8'h20, 24'h100000);
    allow_at(24'h100000, 1'b0, 1'b1, "R9");
    check(rd_valid, 1'b0, "R9", "rd_valid other op");
    send(8'h7E, 24'h0);
    send(8'h39, 24'h450000);
    allow_at(24'h050000, 1'b0, 1'b1, "R2");
    allow_at(24'hC5FFFF, 1'b0, 1'b1, "R2");
  endtask

  task automatic t_por;
    send(8'h98, 24'h0);
    @(negedge clk); por_pulse = 1'b1;
    @(negedge clk); por_pulse = 1'b0;
    allow_at(24'h200000, 1'b0, 1'b0, "R1");
    @(negedge clk);
    por_pulse = 1'b1; cmd_valid = 1'b1; cmd_op = 8'h98; cmd_addr = 24'h0;
    @(negedge clk);
    por_pulse = 1'b0; cmd_valid = 1'b0;
    allow_at(24'h200000, 1'b0, 1'b0, "R1");
    allow_at(24'h000000, 1'b1, 1'b0, "R1");
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_interior();
    t_edge_sectors();
    t_read();
    t_relock();
    t_wps_off();
    t_global();
    t_ignored();
    t_por();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule